// File: doc/BRIEF.md
# Speculative Load-Store Ordering Unit

This block keeps an age-ordered window of in-flight memory operations and decides, cycle by cycle, which load may be sent to memory. Operations enter in program order through an allocation port, which returns the slot index. Addresses arrive later, in any order, on a resolve port that names the slot. Each cycle the block grants at most one load through the issue port. Entries retire in order from the head through a commit strobe.

A static mode input selects between two policies. In the cautious policy, a load waits until every older store in the window has a known address. In the speculative policy, a load whose alias predictor entry was saturated when it was allocated may go ahead of older stores whose addresses are still unknown. The predictor is a table of 2-bit saturating counters indexed by low bits of the load's instruction address. In either policy, a load whose address matches a known older store is held until that store commits, so the pair completes in program order.

Each time a store address resolves, the block compares it against the younger loads that have already issued. On a match it raises a one-cycle replay request naming the oldest offending load and clears that load's predictor counter. The surrounding pipeline answers with a flush that discards that load and everything younger. The pipeline then re-allocates the discarded work.

Top module: `ldst_disambig_unit`

## Requirements
- R1: After reset the window is empty: `alloc_ready`=1, `alloc_idx`=0, `issue_valid`=0 and `replay_valid`=0.
- R2: With `spec_mode`=0, no load is granted while any older live store has no address. A store resolving in the current cycle counts as known.
- R3: With `spec_mode`=1, a load is granted past older unresolved stores when the counter selected by its `alloc_pc` was at its maximum value 3 at allocation.
- R4: When the last older store blocking a ready load resolves to a different address, the load is granted in that same cycle.
- R5: A load whose address equals that of a known older live store is not granted until that store has committed. It may be granted in the cycle right after the commit.
- R6: When a store resolves to an address equal to that of an issued younger load, `replay_valid` pulses in the next cycle, with `replay_idx` set to the oldest such load.
- R7: Predictor counters reset to 0. Each committed load that had issued raises its counter by one, saturating at 3. A replay resets the offending load's counter to 0, so the next load with that PC waits behind unresolved stores.
- R8: A flush at `flush_idx` removes that entry and all younger entries. The next allocation then uses index `flush_idx`.
- R9: At most one load is granted per cycle, and the oldest eligible load wins.
- R10: Slots are handed out in increasing order modulo the depth (8 by default). `alloc_ready` is 0 while all slots are live. A commit frees the head slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spec_mode | input | 1 | Static policy select: 1 speculative, 0 cautious |
| alloc_valid | input | 1 | Allocate one operation at the tail |
| alloc_store | input | 1 | Operation kind: 1 store, 0 load |
| alloc_pc | input | PRED_IDX_W | Low instruction-address bits that select the predictor counter |
| alloc_ready | output | 1 | A slot is free |
| alloc_idx | output | IDX_W | Slot the next allocation will occupy |
| res_valid | input | 1 | Address resolve strobe |
| res_idx | input | IDX_W | Slot whose address is resolving |
| res_addr | input | ADDR_W | Resolved address |
| issue_valid | output | 1 | A load is granted this cycle |
| issue_idx | output | IDX_W | Slot of the granted load |
| commit_valid | input | 1 | Retire the head entry |
| replay_valid | output | 1 | Ordering violation detected in the previous cycle |
| replay_idx | output | IDX_W | Oldest load to be replayed |
| flush_valid | input | 1 | Discard an entry and all younger ones |
| flush_idx | input | IDX_W | Oldest slot to discard |

## Verification
Two functions can fall in the same cycle: a store address resolving and a load grant. The issue logic treats the resolving store as already known. A non-matching address therefore releases a waiting load in that very cycle, and a matching one holds it instead of letting it issue into a violation. The bench provokes this by driving the resolve of a blocking store while a younger load is otherwise ready. It judges the result combinationally in that cycle and through the replay output one cycle later. A random cautious-mode phase with aliasing-prone addresses repeats the collision many times, comparing each cycle's grant with the oldest eligible load computed by a bench function.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
   typedef enum logic {KIND_LOAD = 1'b0, KIND_STORE = 1'b1} op_kind_e;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/ldst_alias_pred.sv
module ldst_alias_pred #(
   parameter int IW = 4,
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] rd_idx,
   output logic          rd_sat,
   input  logic          inc_en,
   input  logic [IW-1:0] inc_idx,
   input  logic          clr_en,
   input  logic [IW-1:0] clr_idx
);
   localparam int ENTRIES = 1 << IW;
   localparam logic [CW-1:0] SAT = '1;

   if (CW < 1) begin : g_bad_cw
      $error("ldst_alias_pred: CW must be at least 1");
   end

   logic [CW-1:0] ctr [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) ctr[e] <= '0;
      end else begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (clr_en && clr_idx == IW'(e))
               ctr[e] <= '0;
            else if (inc_en && inc_idx == IW'(e) && ctr[e] != SAT)
               ctr[e] <= ctr[e] + 1'b1;
         end
      end
   end

   assign rd_sat = (ctr[rd_idx] == SAT);
endmodule

// File: rtl/ldst_age_pick.sv
module ldst_age_pick #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] base,
   output logic          found,
   output logic [IW-1:0] idx
);
   if ((1 << IW) != N) begin : g_bad_n
      $error("ldst_age_pick: N must equal 2**IW");
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int o = N - 1; o >= 0; o--) begin
         if (req[base + IW'(o)]) begin
            found = 1'b1;
            idx   = base + IW'(o);
         end
      end
   end
endmodule

// File: rtl/ldst_disambig_unit.sv
module ldst_disambig_unit #(
   parameter int DEPTH      = 8,
   parameter int ADDR_W     = 32,
   parameter int PRED_IDX_W = 4,
   parameter int CTR_W      = 2,
   parameter bit SPEC_EN    = 1'b1,
   localparam int IDX_W     = ldst_pkg::idx_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spec_mode,
   input  logic              alloc_valid,
   input  logic              alloc_store,
   input  logic [PRED_IDX_W-1:0] alloc_pc,
   output logic              alloc_ready,
   output logic [IDX_W-1:0]  alloc_idx,
   input  logic              res_valid,
   input  logic [IDX_W-1:0]  res_idx,
   input  logic [ADDR_W-1:0] res_addr,
   output logic              issue_valid,
   output logic [IDX_W-1:0]  issue_idx,
   input  logic              commit_valid,
   output logic              replay_valid,
   output logic [IDX_W-1:0]  replay_idx,
   input  logic              flush_valid,
   input  logic [IDX_W-1:0]  flush_idx
);
   import ldst_pkg::*;
   localparam int CNT_W = IDX_W + 1;

   if ((1 << IDX_W) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("ldst_disambig_unit: DEPTH must be a power of two of at least 2");
   end

   // window state
   logic [IDX_W-1:0]      head;
   logic [CNT_W-1:0]      count;
   logic [DEPTH-1:0]      e_store, e_aok, e_iss, e_pok;
   logic [ADDR_W-1:0]     e_addr [DEPTH];
   logic [PRED_IDX_W-1:0] e_pidx [DEPTH];

   logic [IDX_W-1:0]  offs [DEPTH];
   logic [DEPTH-1:0]  live_vec, known_vec, ready_vec, viol_req;
   logic [ADDR_W-1:0] view_addr [DEPTH];
   logic              spec_on;

   if (SPEC_EN) begin : g_spec
      assign spec_on = spec_mode;
   end else begin : g_nospec
      assign spec_on = 1'b0;
   end

   for (genvar j = 0; j < DEPTH; j++) begin : g_ent
      assign offs[j]      = IDX_W'(j) - head;
      assign live_vec[j]  = {1'b0, offs[j]} < count;
      assign known_vec[j] = e_aok[j] | (res_valid && res_idx == IDX_W'(j));
      assign view_addr[j] = e_aok[j] ? e_addr[j] : res_addr;
   end

   // load eligibility against every older store
   always_comb begin
      for (int j = 0; j < DEPTH; j++) begin
         logic hold_unk, hold_hit;
         hold_unk = 1'b0;
         hold_hit = 1'b0;
         for (int k = 0; k < DEPTH; k++) begin
            if (live_vec[k] && e_store[k] && offs[k] < offs[j]) begin
               if (!known_vec[k])
                  hold_unk = 1'b1;
               else if (view_addr[k] == e_addr[j])
                  hold_hit = 1'b1;
            end
         end
         ready_vec[j] = live_vec[j] && (e_store[j] == KIND_LOAD) && e_aok[j] &&
                        !e_iss[j] && !hold_hit && (!hold_unk || (spec_on && e_pok[j]));
      end
   end

   ldst_age_pick #(.N(DEPTH), .IW(IDX_W)) u_issue_pick (
      .req(ready_vec), .base(head), .found(issue_valid), .idx(issue_idx)
   );

   // violation check on the resolve port
   logic res_is_store;
   assign res_is_store = res_valid && live_vec[res_idx] && e_store[res_idx];

   always_comb begin
      for (int j = 0; j < DEPTH; j++) begin
         viol_req[j] = res_is_store && live_vec[j] && !e_store[j] && e_iss[j] &&
                       e_aok[j] && e_addr[j] == res_addr && offs[j] > offs[res_idx];
      end
   end

   logic             viol_found;
   logic [IDX_W-1:0] viol_idx;

   ldst_age_pick #(.N(DEPTH), .IW(IDX_W)) u_viol_pick (
      .req(viol_req), .base(head), .found(viol_found), .idx(viol_idx)
   );

   // predictor
   logic tail_full, commit_fire, flush_fire, alloc_fire, pred_sat, train_inc;
   logic [IDX_W-1:0] flush_off;

   assign tail_full   = (count == CNT_W'(DEPTH));
   assign alloc_ready = !tail_full;
   assign alloc_idx   = head + count[IDX_W-1:0];
   assign flush_off   = flush_idx - head;
   assign flush_fire  = flush_valid && live_vec[flush_idx];
   assign commit_fire = commit_valid && count != '0 && !(flush_fire && flush_off == '0);
   assign alloc_fire  = alloc_valid && !tail_full && !flush_valid;
   assign train_inc   = commit_fire && !e_store[head] && e_iss[head];

   ldst_alias_pred #(.IW(PRED_IDX_W), .CW(CTR_W)) u_pred (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(alloc_pc), .rd_sat(pred_sat),
      .inc_en(train_inc), .inc_idx(e_pidx[head]),
      .clr_en(viol_found), .clr_idx(e_pidx[viol_idx])
   );

   // sequential state
   logic [CNT_W-1:0] cnt_base;
   assign cnt_base = flush_fire ? {1'b0, flush_off} : count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head         <= '0;
         count        <= '0;
         e_store      <= '0;
         e_aok        <= '0;
         e_iss        <= '0;
         e_pok        <= '0;
         replay_valid <= 1'b0;
         replay_idx   <= '0;
      end else begin
         replay_valid <= viol_found;
         replay_idx   <= viol_idx;
         if (res_valid && live_vec[res_idx]) e_aok[res_idx] <= 1'b1;
         if (issue_valid) e_iss[issue_idx] <= 1'b1;
         if (alloc_fire) begin
            e_store[alloc_idx] <= alloc_store;
            e_aok[alloc_idx]   <= 1'b0;
            e_iss[alloc_idx]   <= 1'b0;
            e_pok[alloc_idx]   <= pred_sat;
         end
         if (commit_fire) head <= head + 1'b1;
         count <= cnt_base - CNT_W'(commit_fire) + CNT_W'(alloc_fire);
      end
   end

   always_ff @(posedge clk) begin
      if (res_valid && live_vec[res_idx]) e_addr[res_idx] <= res_addr;
      if (alloc_fire) e_pidx[alloc_idx] <= alloc_pc;
   end
endmodule

// File: rtl/ldst_disambig_chk.sv
module ldst_disambig_chk #(
   parameter int DEPTH = 8,
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             spec_mode,
   input logic             alloc_ready,
   input logic             issue_valid,
   input logic [IDX_W-1:0] issue_idx,
   input logic             res_valid,
   input logic [IDX_W-1:0] res_idx,
   input logic             replay_valid,
   input logic             flush_valid,
   input logic [IDX_W-1:0] flush_idx,
   input logic             commit_valid,
   input logic [IDX_W-1:0] head,
   input logic [IDX_W:0]   count,
   input logic [DEPTH-1:0] live_vec,
   input logic [DEPTH-1:0] e_store,
   input logic [DEPTH-1:0] e_aok,
   input logic [DEPTH-1:0] e_iss
);
   logic             older_unres;
   logic [IDX_W-1:0] fl_off;

   assign fl_off = flush_idx - head;

   always_comb begin
      older_unres = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
         if (live_vec[k] && e_store[k] && !e_aok[k] &&
             !(res_valid && res_idx == IDX_W'(k)) &&
             (IDX_W'(k) - head) < (issue_idx - head))
            older_unres = 1'b1;
      end
   end

   a_r2_cautious_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!spec_mode && issue_valid) |-> !older_unres);

   a_r9_grant_target: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (live_vec[issue_idx] && !e_store[issue_idx] &&
                       e_aok[issue_idx] && !e_iss[issue_idx]));

   a_r6_replay_cause: assert property (@(posedge clk) disable iff (!rst_n)
      replay_valid |-> $past(res_valid));

   a_r8_flush_trim: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_valid && live_vec[flush_idx] && !commit_valid) |=>
         count == {1'b0, $past(fl_off)});

   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= (IDX_W+1)'(DEPTH));

   a_r10_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (count == (IDX_W+1)'(DEPTH)) |-> !alloc_ready);
endmodule

bind ldst_disambig_unit ldst_disambig_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .spec_mode(spec_mode), .alloc_ready(alloc_ready),
   .issue_valid(issue_valid), .issue_idx(issue_idx),
   .res_valid(res_valid), .res_idx(res_idx), .replay_valid(replay_valid),
   .flush_valid(flush_valid), .flush_idx(flush_idx), .commit_valid(commit_valid),
   .head(head), .count(count), .live_vec(live_vec),
   .e_store(e_store), .e_aok(e_aok), .e_iss(e_iss)
);

// File: tb/tb_ldst_disambig_unit.sv
module tb_ldst_disambig_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spec_mode = 1'b0;
   logic        alloc_valid = 1'b0, alloc_store = 1'b0;
   logic [3:0]  alloc_pc = '0;
   logic        alloc_ready;
   logic [2:0]  alloc_idx;
   logic        res_valid = 1'b0;
   logic [2:0]  res_idx = '0;
   logic [31:0] res_addr = '0;
   logic        issue_valid;
   logic [2:0]  issue_idx;
   logic        commit_valid = 1'b0;
   logic        replay_valid;
   logic [2:0]  replay_idx;
   logic        flush_valid = 1'b0;
   logic [2:0]  flush_idx = '0;

   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   ldst_disambig_unit dut (
      .clk(clk), .rst_n(rst_n), .spec_mode(spec_mode),
      .alloc_valid(alloc_valid), .alloc_store(alloc_store), .alloc_pc(alloc_pc),
      .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
      .res_valid(res_valid), .res_idx(res_idx), .res_addr(res_addr),
      .issue_valid(issue_valid), .issue_idx(issue_idx),
      .commit_valid(commit_valid),
      .replay_valid(replay_valid), .replay_idx(replay_idx),
      .flush_valid(flush_valid), .flush_idx(flush_idx)
   );

   // bench shadow of the window, built from what the bench drove
   bit        sh_store [8];
   bit        sh_aok   [8];
   bit        sh_iss   [8];
   int        sh_addr  [8];
   int        sh_head, sh_cnt;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #2;
      alloc_valid = 0; res_valid = 0; commit_valid = 0; flush_valid = 0;
   endtask

   task automatic do_alloc(input bit st, input logic [3:0] pc, output int idx);
      alloc_valid = 1; alloc_store = st; alloc_pc = pc; #1;
      idx = alloc_idx;
      tick();
   endtask

   task automatic do_res(input int idx, input int a);
      res_valid = 1; res_idx = 3'(idx); res_addr = a;
      tick();
   endtask

   task automatic do_commit();
      commit_valid = 1;
      tick();
   endtask

   task automatic expect_quiet(input string req, input int n);
      for (int c = 0; c < n; c++) begin
         #5 chk(!issue_valid, req, issue_valid, 0);
         tick();
      end
   endtask

   // oldest load that the cautious policy allows this cycle
   function automatic int exp_pick();
      for (int o = 0; o < sh_cnt; o++) begin
         int j = (sh_head + o) % 8;
         if (!sh_store[j] && sh_aok[j] && !sh_iss[j]) begin
            bit ok = 1;
            for (int p = 0; p < o; p++) begin
               int k = (sh_head + p) % 8;
               if (sh_store[k]) begin
                  bit kn = sh_aok[k] || (res_valid && res_idx == 3'(k));
                  int ka = sh_aok[k] ? sh_addr[k] : int'(res_addr);
                  if (!kn || ka == sh_addr[j]) ok = 0;
               end
            end
            if (ok) return j;
         end
      end
      return -1;
   endfunction

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int s, l, la, lb, s2, l2, l1, first, x;
      void'($urandom(32'h5eed_1234));
      #25 rst_n = 1;
      @(posedge clk); #2;
      #5;
      chk(alloc_ready, "R1 ready", alloc_ready, 1);
      chk(alloc_idx == 0, "R1 idx", alloc_idx, 0);
      chk(!issue_valid && !replay_valid, "R1 idle", issue_valid, 0);
      tick();

      // cautious: load waits behind unknown store, released in resolve cycle
      spec_mode = 0;
      do_alloc(1, 5, s); do_alloc(0, 5, l); do_res(l, 'h40);
      expect_quiet("R2", 3);
      res_valid = 1; res_idx = 3'(s); res_addr = 'h80;
      #5 chk(issue_valid && issue_idx == 3'(l), "R4 same-cycle grant", issue_idx, l);
      tick();
      do_commit(); do_commit();

      // known matching older store holds the load until it commits
      do_alloc(1, 5, s); do_alloc(0, 5, l); do_res(s, 'h40); do_res(l, 'h40);
      expect_quiet("R5", 3);
      do_commit();
      #5 chk(issue_valid && issue_idx == 3'(l), "R5 after commit", issue_idx, l);
      tick();
      do_commit();

      // third clean commit for pc 5 saturates its counter
      do_alloc(0, 5, l); do_res(l, 'h10);
      #5 chk(issue_valid && issue_idx == 3'(l), "R9 lone load", issue_idx, l);
      tick();
      do_commit();

      // speculative bypass, then violation, replay and flush
      spec_mode = 1;
      do_alloc(1, 5, s); do_alloc(0, 5, la); do_alloc(0, 5, lb);
      do_res(la, 'h50);
      res_valid = 1; res_idx = 3'(lb); res_addr = 'h50;
      #5 chk(issue_valid && issue_idx == 3'(la), "R3 bypass a", issue_idx, la);
      tick();
      #5 chk(issue_valid && issue_idx == 3'(lb), "R3 bypass b", issue_idx, lb);
      tick();
      res_valid = 1; res_idx = 3'(s); res_addr = 'h50;
      #5 chk(!replay_valid, "R6 not early", replay_valid, 0);
      tick();
      #5 chk(replay_valid && replay_idx == 3'(la), "R6 oldest", replay_idx, la);
      flush_valid = 1; flush_idx = 3'(la);
      tick();
      #1 chk(alloc_idx == 3'(la), "R8 tail", alloc_idx, la);
      chk(!replay_valid, "R6 pulse", replay_valid, 0);
      do_commit();

      // counter was cleared: pc 5 waits again in speculative mode
      do_alloc(1, 5, s2); do_alloc(0, 5, l2); do_res(l2, 'h44);
      expect_quiet("R7", 3);
      res_valid = 1; res_idx = 3'(s2); res_addr = 'h88;
      #5 chk(issue_valid && issue_idx == 3'(l2), "R4 spec release", issue_idx, l2);
      tick();
      do_commit(); do_commit();

      // two ready loads released together: oldest first
      spec_mode = 0;
      do_alloc(1, 1, s); do_alloc(0, 1, l1); do_alloc(0, 2, l2);
      do_res(l2, 'h200); do_res(l1, 'h204);
      res_valid = 1; res_idx = 3'(s); res_addr = 'h300;
      #5 chk(issue_valid && issue_idx == 3'(l1), "R9 oldest", issue_idx, l1);
      tick();
      #5 chk(issue_valid && issue_idx == 3'(l2), "R9 next", issue_idx, l2);
      tick();
      do_commit(); do_commit(); do_commit();

      // fill and drain
      #1 first = alloc_idx;
      for (int i = 0; i < 8; i++) begin
         do_alloc(1, 0, x);
         chk(x == (first + i) % 8, "R10 order", x, (first + i) % 8);
      end
      #1 chk(!alloc_ready, "R10 full", alloc_ready, 0);
      do_commit();
      #1 chk(alloc_ready && alloc_idx == 3'(first), "R10 freed", alloc_idx, first);
      for (int i = 0; i < 7; i++) do_commit();

      // random cautious-mode phase
      #1 sh_head = alloc_idx; sh_cnt = 0;
      for (int c = 0; c < 2000; c++) begin
         bit a_do, r_do, c_do;
         int r_sel, e_pick, a_slot, g_idx;
         bit g_do;
         a_do = (c < 1800) && sh_cnt < 8 && ($urandom % 2 == 1);
         alloc_valid = a_do; alloc_store = $urandom % 2; alloc_pc = 4'($urandom);
         r_do = 0; r_sel = 0;
         if ($urandom % 2 == 1) begin
            int st = $urandom % 8;
            for (int o = 0; o < sh_cnt && !r_do; o++) begin
               int j = (sh_head + (st + o) % sh_cnt) % 8;
               if (!sh_aok[j]) begin r_do = 1; r_sel = j; end
            end
         end
         res_valid = r_do; res_idx = 3'(r_sel); res_addr = 'h100 + 4 * ($urandom % 4);
         c_do = sh_cnt > 0 && ($urandom % 2 == 1) &&
                (sh_store[sh_head] ? sh_aok[sh_head] : sh_iss[sh_head]);
         commit_valid = c_do;
         #5;
         e_pick = exp_pick();
         chk(issue_valid == (e_pick >= 0) && (e_pick < 0 || issue_idx == 3'(e_pick)),
             "R2/R9 random grant", issue_valid ? int'(issue_idx) : -1, e_pick);
         chk(!replay_valid, "R6 cautious no replay", replay_valid, 0);
         chk(alloc_ready == (sh_cnt < 8), "R10 random ready", alloc_ready, sh_cnt < 8);
         a_slot = (sh_head + sh_cnt) % 8;
         if (a_do) chk(alloc_idx == 3'(a_slot), "R10 random slot", alloc_idx, a_slot);
         g_do = issue_valid; g_idx = issue_idx;
         tick();
         if (g_do) sh_iss[g_idx] = 1;
         if (r_do) begin sh_aok[r_sel] = 1; sh_addr[r_sel] = int'(res_addr); end
         if (a_do) begin
            sh_store[a_slot] = alloc_store; sh_aok[a_slot] = 0; sh_iss[a_slot] = 0;
            sh_cnt++;
         end
         if (c_do) begin sh_head = (sh_head + 1) % 8; sh_cnt--; end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule